// File: doc/BRIEF.md
# Shared-Exponent Float Block Compressor

This block takes a stream of single-precision floating-point feature values and turns every group of 32 of them into one fixed-size packed word. As the values arrive, the block stores them and keeps a running maximum of their exponents. That maximum becomes the exponent shared by the whole group. In a second pass it reads the stored values back one per cycle. For each value it aligns the significand to the shared exponent, keeps only the top `MANT_W` bits, and writes the sign and the reduced magnitude into a fixed lane of the output word.

A controller runs three states, FILL, PACK and EMIT, and moves through them in a fixed cycle:

- **FILL** accepts input words. It goes to PACK when the 32nd word is accepted.
- **PACK** encodes one lane per cycle. It goes to EMIT after the lane for element 31.
- **EMIT** offers the packed word. It returns to FILL when `out_ready` is seen.

Both ends use a valid/ready handshake. Because every group produces a word of the same width, compressed storage is predictable whatever the data.

Top module: `fp_blockpack`

## Requirements
- R1: Exactly 32 input words are accepted (a cycle with both `in_valid` and `in_ready` high) per group. `out_valid` stays low until the 32nd of them has been accepted, and each group produces exactly one output word.
- R2: From the 32nd accept until the output word is taken, `in_ready` is low. `in_valid` in that window has no effect. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. One cycle after `out_valid && out_ready`, `out_valid` is low and `in_ready` is high.
- R3: The effective exponent of an input is its 8-bit exponent field (bits 30:23), with two exceptions: a field of 0 counts as 1 and a field of 255 counts as 254. `out_data[W-1:W-8]` is the largest effective exponent in the group.
- R4: Below the exponent, element k (0 = first accepted) takes the (1+M)-bit lane `out_data[W-9-k*(1+M) -: 1+M]`. The lane's MSB is the input sign (bit 31) and the low M bits are the magnitude. W = 8 + 32*(1+M), where M is the `MANT_W` parameter (8 or 10).
- R5: The magnitude is the 24-bit significand (leading bit, then bits 22:0) shifted right by the shared exponent minus the element's effective exponent, keeping the top M of 24 bits. A difference of 24 or more gives zero.
- R6: Bits shifted below the M kept bits are dropped with no rounding.
- R7: An input with exponent field 0 and fraction 0 gives magnitude zero and keeps its sign, so -0 gives lane 1 followed by zeros. A group of only zeros has shared exponent 1.
- R8: A subnormal input (exponent field 0, fraction non-zero) uses a leading bit of 0 and effective exponent 1.
- R9: An input with exponent field 255 (infinity or NaN) gives an all-ones magnitude with its sign kept, and counts as effective exponent 254.
- R10: After reset `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Single-precision input value |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Downstream takes the packed word |
| out_data | output | 8+32*(MANT_W+1) | Shared exponent followed by 32 lanes |

## Verification
The hardest state to reach is EMIT held under back-pressure while the upstream keeps offering data. This tests whether a stray input is absorbed into the next group or disturbs the held word. The stimulus holds `out_ready` low for several cycles after the word appears and drives `in_valid` with junk data throughout. It then checks each cycle that `out_data` is stable, and finally sends a fresh group whose packed result would show any absorbed word. Exponent spreads just under and far over the kept width are also set up on purpose, since ordinary data rarely exercises them.

// File: rtl/fpbc_pkg.sv
package fpbc_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_PACK = 2'd1,
        ST_EMIT = 2'd2
    } phase_t;

    // Exponent used for alignment: subnormals sit at 1, inf/NaN clamp to 254.
    function automatic logic [EXP_W-1:0] eff_exp(input logic [EXP_W-1:0] e);
        if (e == '0)
            return EXP_W'(1);
        else if (e == '1)
            return EXP_W'(254);
        else
            return e;
    endfunction
endpackage

// File: rtl/fpbc_exp_max.sv
module fpbc_exp_max #(
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [EW-1:0] exp_in,
    output logic [EW-1:0] max_o
);
    logic [EW-1:0] max_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            max_q <= '0;
        else if (clear)
            max_q <= '0;
        else if (en && (exp_in > max_q))
            max_q <= exp_in;
    end

    assign max_o = max_q;
endmodule

// File: rtl/fpbc_buffer.sv
module fpbc_buffer #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fpbc_lane_enc.sv
module fpbc_lane_enc
    import fpbc_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic [31:0]      word,
    input  logic [EXP_W-1:0] shared,
    output logic [MW:0]      lane
);
    logic [EXP_W-1:0] e_raw;
    logic [EXP_W-1:0] diff;
    logic [SIG_W-1:0] sig;
    logic [SIG_W-1:0] shifted;
    logic [MW-1:0]    mag;

    always_comb begin
        e_raw   = word[30:23];
        sig     = {(e_raw != '0), word[22:0]};
        diff    = shared - eff_exp(e_raw);
        shifted = (diff >= EXP_W'(SIG_W)) ? '0 : (sig >> diff);
        mag     = MW'(shifted >> (SIG_W - MW));
        if (e_raw == '1)
            mag = '1;
        lane = {word[31], mag};
    end
endmodule

// File: rtl/fp_blockpack.sv
module fp_blockpack
    import fpbc_pkg::*;
#(
    parameter int N_ELEM  = 32,
    parameter int MANT_W  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [31:0]                         in_data,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [8+N_ELEM*(MANT_W+1)-1:0]      out_data
);
    localparam int LANE_W = MANT_W + 1;
    localparam int IDX_W  = $clog2(N_ELEM);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ELEM - 1);

    phase_t            state_q, state_d;
    logic [IDX_W-1:0]  cnt_q, cnt_d;
    logic              in_fire, out_fire, pack_en;
    logic [EXP_W-1:0]  shared_exp;
    logic [31:0]       rd_word;
    logic [LANE_W-1:0] lane;
    logic [0:N_ELEM-1][LANE_W-1:0] lanes_q;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: if (in_fire) begin
                if (cnt_q == LAST) begin
                    state_d = ST_PACK;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PACK: begin
                if (cnt_q == LAST) begin
                    state_d = ST_EMIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_EMIT: if (out_ready) state_d = ST_FILL;
            default: state_d = ST_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        pack_en   = 1'b0;
        unique case (state_q)
            ST_FILL: in_ready  = 1'b1;
            ST_PACK: pack_en   = 1'b1;
            ST_EMIT: out_valid = 1'b1;
            default: ;
        endcase
    end

    fpbc_exp_max #(.EW(EXP_W)) u_max (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (out_fire),
        .en     (in_fire),
        .exp_in (eff_exp(in_data[30:23])),
        .max_o  (shared_exp)
    );

    fpbc_buffer #(.DEPTH(N_ELEM), .DW(32)) u_buf (
        .clk   (clk),
        .we    (in_fire),
        .waddr (cnt_q),
        .wdata (in_data),
        .raddr (cnt_q),
        .rdata (rd_word)
    );

    fpbc_lane_enc #(.MW(MANT_W)) u_enc (
        .word   (rd_word),
        .shared (shared_exp),
        .lane   (lane)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lanes_q <= '0;
        else if (pack_en)
            lanes_q[cnt_q] <= lane;
    end

    assign out_data = {shared_exp, lanes_q};
endmodule

// File: rtl/fp_blockpack_chk.sv
module fp_blockpack_chk #(
    parameter int N = 32,
    parameter int W = 296
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data
);
    localparam int CW = $clog2(N + 1);
    logic [CW-1:0] taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            taken <= '0;
        else if (out_valid && out_ready)
            taken <= '0;
        else if (in_valid && in_ready)
            taken <= taken + 1'b1;
    end

    p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (taken == CW'(N)));

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    p_exp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[W-1 -: 8] != 8'd0 && out_data[W-1 -: 8] != 8'd255));
endmodule

bind fp_blockpack fp_blockpack_chk #(.N(N_ELEM), .W(8 + N_ELEM*(MANT_W+1))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/fp_blockpack_test.sv
module fp_blockpack_test;
    localparam int NE = 32;
    localparam int MW = 8;
    localparam int LW = MW + 1;
    localparam int OW = 8 + NE*LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [OW-1:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0]   blk [NE];
    logic [OW-1:0] got;

    always #5 clk = ~clk;

    fp_blockpack #(.N_ELEM(NE), .MANT_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
        return {s, 8'(e), f};
    endfunction

    function automatic int effx(input logic [31:0] v);
        int e = int'(v[30:23]);
        if (e == 0) return 1;
        if (e == 255) return 254;
        return e;
    endfunction

    // Reference built from R3..R9
    function automatic logic [OW-1:0] model();
        logic [OW-1:0] r = '0;
        int sh = 0;
        for (int i = 0; i < NE; i++) if (effx(blk[i]) > sh) sh = effx(blk[i]);
        r[OW-1 -: 8] = 8'(sh);
        for (int i = 0; i < NE; i++) begin
            logic [23:0] s = {blk[i][30:23] != 0, blk[i][22:0]};
            int d = sh - effx(blk[i]);
            logic [MW-1:0] m;
            if (d >= 24) s = 0; else s = s >> d;
            m = s[23 -: MW];
            if (blk[i][30:23] == 8'hFF) m = '1;
            r[OW-9-i*LW -: LW] = {blk[i][31], m};
        end
        return r;
    endfunction

    function automatic logic [LW-1:0] lane(input logic [OW-1:0] w, input int k);
        return w[OW-9-k*LW -: LW];
    endfunction

    task automatic chk(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int gap, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = blk[i];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            if (gap > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pull(output logic [OW-1:0] w);
        @(negedge clk);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        w = out_data;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_block(input string req);
        logic [OW-1:0] w;
        push(0, NE);
        pull(w);
        got = w;
        chk(req, w, model());
    endtask

    task automatic t_reset();
        chk("R10 in_ready", OW'(in_ready), OW'(1));
        chk("R10 out_valid", OW'(out_valid), OW'(0));
    endtask

    task automatic t_uniform();
        for (int i = 0; i < NE; i++) blk[i] = 32'h3F80_0000;
        run_block("R1 R4 uniform word");
        chk("R3 shared exp", OW'(got[OW-1 -: 8]), OW'(127));
        chk("R4 lane0", OW'(lane(got, 0)), OW'(9'b0_1000_0000));
    endtask

    task automatic t_mixed();
        for (int i = 0; i < NE; i++) blk[i] = mk(i[0], 127 + (i % 8), 23'h40_0000);
        run_block("R5 mixed word");
        chk("R3 max exp", OW'(got[OW-1 -: 8]), OW'(134));
        chk("R5 diff0 lane7", OW'(lane(got, 7)), OW'(9'b1_1100_0000));
        chk("R6 truncate lane0", OW'(lane(got, 0)), OW'(9'b0_0000_0001));
    endtask

    task automatic t_zero();
        for (int i = 0; i < NE; i++) blk[i] = (i % 3 == 0) ? 32'h8000_0000 : 32'h0;
        run_block("R7 zero word");
        chk("R7 shared one", OW'(got[OW-1 -: 8]), OW'(1));
        chk("R7 neg zero", OW'(lane(got, 3)), OW'(9'b1_0000_0000));
    endtask

    task automatic t_sub();
        for (int i = 0; i < NE; i++) blk[i] = (i < 16) ? 32'h0040_0000 : 32'h0080_0000;
        run_block("R8 subnormal word");
        chk("R8 sub lane", OW'(lane(got, 0)), OW'(9'b0_0100_0000));
        chk("R8 min normal", OW'(lane(got, 20)), OW'(9'b0_1000_0000));
    endtask

    task automatic t_spread();
        for (int i = 0; i < NE; i++) blk[i] = mk(1'b0, 150, 23'h7F_FFFF);
        blk[0] = mk(1'b0, 200, 23'h0);
        blk[1] = mk(1'b1, 193, 23'h0);
        blk[2] = mk(1'b0, 176, 23'h7F_FFFF);
        run_block("R5 spread word");
        chk("R5 diff7", OW'(lane(got, 1)), OW'(9'b1_0000_0001));
        chk("R5 diff24 zero", OW'(lane(got, 2)), OW'(9'b0_0000_0000));
        chk("R5 diff50 zero", OW'(lane(got, 9)), OW'(9'b0_0000_0000));
    endtask

    task automatic t_inf();
        for (int i = 0; i < NE; i++) blk[i] = 32'h3F80_0000;
        blk[4] = 32'h7F80_0000;
        blk[9] = 32'hFFC0_0000;
        run_block("R9 special word");
        chk("R9 shared 254", OW'(got[OW-1 -: 8]), OW'(254));
        chk("R9 pos inf", OW'(lane(got, 4)), OW'(9'b0_1111_1111));
        chk("R9 neg nan", OW'(lane(got, 9)), OW'(9'b1_1111_1111));
    endtask

    task automatic t_gaps();
        logic [OW-1:0] w;
        for (int i = 0; i < NE; i++) blk[i] = mk(i[1], 100 + i, 23'(i * 4099));
        push(3, NE - 1);
        repeat (5) @(negedge clk);
        chk("R1 no early word", OW'(out_valid), OW'(0));
        chk("R1 still filling", OW'(in_ready), OW'(1));
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = blk[NE-1];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        pull(w);
        chk("R1 gapped word", w, model());
    endtask

    task automatic t_backpressure();
        logic [OW-1:0] first;
        for (int i = 0; i < NE; i++) blk[i] = mk(1'b0, 120 + (i % 5), 23'h12_3456);
        @(negedge clk);
        out_ready = 1'b0;
        push(0, NE);
        while (!out_valid) @(negedge clk);
        first = out_data;
        chk("R2 held word", first, model());
        in_valid = 1'b1;
        in_data  = 32'h7F7F_FFFF;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R2 stays valid", OW'(out_valid), OW'(1));
            chk("R2 stable data", out_data, first);
            chk("R2 no input", OW'(in_ready), OW'(0));
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 released", OW'(out_valid), OW'(0));
        for (int i = 0; i < NE; i++) blk[i] = mk(1'b1, 90, 23'h0);
        run_block("R2 stray not absorbed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_mixed();
        t_zero();
        t_sub();
        t_spread();
        t_inf();
        t_gaps();
        t_backpressure();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule